// File: doc/BRIEF.md
# Receive Frame Page Writer

This block takes a received Ethernet frame, delivered one byte per cycle with a marker on its final byte, and lays it out inside a single packet page of buffer memory. A page is requested from an external page allocator on the first byte of a frame. Frame bytes are written into the page as they arrive. When the frame ends, the block adds zero padding for runt frames, the CRC-32 when it is kept, a two-byte trailer and a four-byte header. It then hands the page number to the receive queue.

A frame is accepted only while the receive-control word enables reception and does not hold the block in soft reset, and only when the allocator grants a page. A frame whose stored image would not fit in one page is dropped, and its page goes back to the allocator. The block stores one frame at a time. While it is still finishing one frame, anything new that arrives on the input is discarded up to that frame's end marker.

Top module: `rx_page_writer`

## Requirements
- R1: A frame is stored only if, on its first byte, receive-control bit 8 (enable) is 1, bit 15 (soft reset) is 0 and the allocator grants a page. The block raises `alloc_req` only when both control bits allow reception. A refused frame causes no page write and no push.
- R2: A frame shorter than MIN_FRAME bytes is extended with zero bytes to MIN_FRAME bytes. These zero bytes are stored and included in the CRC.
- R3: Page bytes 2 (low) and 3 (high) hold the stored size. The size is the padded length rounded down to even, plus 6, plus 4 more when receive-control bit 9 (strip CRC) is 0.
- R4: When the stored size would exceed PAGE_BYTES, nothing is pushed and `release_valid` pulses once with the page on `cur_page`.
- R5: Page bytes 0 (low) and 1 (high) hold a status word. Bit 11 is set when the padded length exceeds LONG_FRAME, and bit 12 is set when the padded length is odd. All other bits are 0.
- R6: The frame bytes, truncated to an even count, are stored from page offset 4 onward in arrival order.
- R7: When the CRC is kept, the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, result inverted) over the padded frame is stored low byte first, directly after the even data.
- R8: The two bytes after the CRC (or after the data when the CRC is stripped) are the odd last frame byte followed by 0x20 for an odd length. They are both 0x00 for an even length.
- R9: A stored frame ends with a single-cycle `push_valid` pulse, which pushes `cur_page` to the receive queue and raises the receive interrupt. The pulse comes in the same cycle as the last header write.
- R10: Bytes that arrive while a previous frame is still being finished are ignored, together with the rest of the frame they belong to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rcv_ctrl | input | 16 | Receive-control word: bit 8 enable, bit 9 strip CRC, bit 15 soft reset |
| in_valid | input | 1 | Frame byte present |
| in_byte | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| alloc_req | output | 1 | Page request, combinational on the first byte |
| alloc_grant | input | 1 | Allocator has a free page, same cycle |
| alloc_page | input | PAGE_NUM_W | Granted page number |
| cur_page | output | PAGE_NUM_W | Page being written, pushed or released |
| wr_en | output | 1 | Page byte write strobe |
| wr_addr | output | log2(PAGE_BYTES) | Byte offset inside the page |
| wr_data | output | 8 | Byte written |
| push_valid | output | 1 | Page pushed to receive queue; receive interrupt raise |
| release_valid | output | 1 | Page returned after an oversize drop |

## Verification
The bench builds the block with PAGE_BYTES at 256 and LONG_FRAME at 200, keeping MIN_FRAME at 64 and PAGE_NUM_W at 6. With a small page, frames of only a couple of hundred bytes reach both sides of the page-fit limit: 250 bytes with the CRC stripped and 247 bytes with it kept each fill the page exactly, while 248 bytes with the CRC kept overflow it. The same short frames also set the too-long flag. Runt frames of 1, 10 and 63 bytes exercise padding, and an odd frame with the CRC kept places the CRC ahead of the final byte.

// File: rtl/rxw_pkg.sv
`timescale 1ns/1ps
package rxw_pkg;

    localparam int CTRL_RX_EN_BIT = 8;
    localparam int CTRL_STRIP_BIT = 9;
    localparam int CTRL_SRST_BIT  = 15;
    localparam int STAT_LONG_BIT  = 11;
    localparam int STAT_ODD_BIT   = 12;
    localparam logic [7:0]  TRAIL_ODD_MARK = 8'h20;
    localparam logic [31:0] CRC_POLY       = 32'hEDB88320;
    localparam logic [3:0]  LAST_STEP      = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_DISC,
        ST_PAD,
        ST_CHECK,
        ST_TAIL
    } rxw_state_e;

    typedef struct packed {
        logic        odd;
        logic        too_long;
        logic        oversize;
        logic [15:0] size;
        logic [15:0] crc_base;
        logic [15:0] trail;
    } rxw_meta_t;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
    } rxw_wr_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    // Steps 0..3 CRC bytes, 4..5 trailer, 6..9 header.
    function automatic rxw_wr_t tail_write(input logic [3:0] step, input rxw_meta_t m,
                                           input logic [31:0] crc, input logic [7:0] lastb);
        rxw_wr_t     w;
        logic [15:0] status;
        status = 16'd0;
        status[STAT_LONG_BIT] = m.too_long;
        status[STAT_ODD_BIT]  = m.odd;
        w = '0;
        case (step)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                w.addr = m.crc_base + 16'(step);
                w.data = crc[8*step[1:0] +: 8];
            end
            4'd4: begin
                w.addr = m.trail;
                w.data = m.odd ? lastb : 8'h00;
            end
            4'd5: begin
                w.addr = m.trail + 16'd1;
                w.data = m.odd ? TRAIL_ODD_MARK : 8'h00;
            end
            4'd6: begin w.addr = 16'd0; w.data = status[7:0];  end
            4'd7: begin w.addr = 16'd1; w.data = status[15:8]; end
            4'd8: begin w.addr = 16'd2; w.data = m.size[7:0];  end
            default: begin w.addr = 16'd3; w.data = m.size[15:8]; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rxw_crc.sv
`timescale 1ns/1ps
module rxw_crc
    import rxw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_fin
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '1;
        end else if (start) begin
            crc_q <= crc32_step(32'hFFFF_FFFF, din);
        end else if (en) begin
            crc_q <= crc32_step(crc_q, din);
        end
    end

    assign crc_fin = ~crc_q;

    // R7: the running CRC only moves on frame or pad bytes
    assert_crc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!start && !en) |=> $stable(crc_fin));
endmodule

// File: rtl/rxw_meta.sv
`timescale 1ns/1ps
module rxw_meta
    import rxw_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int LONG_FRAME = 1518,
    parameter int CNT_W      = 12
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             strip,
    output rxw_meta_t        meta
);
    logic [15:0] even_len;
    logic [15:0] crc_len;

    always_comb begin
        even_len      = 16'({cnt[CNT_W-1:1], 1'b0});
        crc_len       = strip ? 16'd0 : 16'd4;
        meta.odd      = cnt[0];
        meta.too_long = 16'(cnt) > 16'(LONG_FRAME);
        meta.size     = even_len + 16'd6 + crc_len;
        meta.oversize = meta.size > 16'(PAGE_BYTES);
        meta.crc_base = even_len + 16'd4;
        meta.trail    = meta.crc_base + crc_len;
    end
endmodule

// File: rtl/rx_page_writer.sv
`timescale 1ns/1ps
module rx_page_writer
    import rxw_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int PAGE_NUM_W = 6,
    parameter int MIN_FRAME  = 64,
    parameter int LONG_FRAME = 1518
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [15:0]                   rcv_ctrl,
    input  logic                          in_valid,
    input  logic [7:0]                    in_byte,
    input  logic                          in_last,
    output logic                          alloc_req,
    input  logic                          alloc_grant,
    input  logic [PAGE_NUM_W-1:0]         alloc_page,
    output logic [PAGE_NUM_W-1:0]         cur_page,
    output logic                          wr_en,
    output logic [$clog2(PAGE_BYTES)-1:0] wr_addr,
    output logic [7:0]                    wr_data,
    output logic                          push_valid,
    output logic                          release_valid
);
    localparam int AW    = $clog2(PAGE_BYTES);
    localparam int CNT_W = AW + 1;
    localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_FRAME);
    localparam logic [CNT_W:0]   PAGE_C = (CNT_W+1)'(PAGE_BYTES);

    rxw_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cnt_inc;
    logic                strip_q;
    logic [7:0]          last_q;
    logic [3:0]          step_q;
    logic                swallow_q;
    logic                swallow_nxt;
    rxw_state_e          finish_st;
    logic [CNT_W:0]      data_addr;
    logic                data_in_range;
    logic                rx_ok;
    logic                accept;
    logic                crc_start;
    logic                crc_en;
    logic [7:0]          crc_din;
    logic [31:0]         crc_fin;
    rxw_meta_t           meta;
    rxw_wr_t             tw;
    logic                busy;
    logic [12:0]         ctrl_unused_bits;

    assign ctrl_unused_bits = {rcv_ctrl[14:10], rcv_ctrl[7:0]};

    assign rx_ok     = rcv_ctrl[CTRL_RX_EN_BIT] && !rcv_ctrl[CTRL_SRST_BIT];
    assign alloc_req = (state_q == ST_IDLE) && in_valid && rx_ok;
    assign accept    = alloc_req && alloc_grant;

    assign cnt_inc       = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    assign data_addr     = (CNT_W+1)'(cnt_q) + (CNT_W+1)'(4);
    assign data_in_range = data_addr < PAGE_C;

    assign busy        = (state_q == ST_PAD) || (state_q == ST_CHECK) || (state_q == ST_TAIL);
    assign swallow_nxt = in_valid ? !in_last : swallow_q;
    assign finish_st   = swallow_nxt ? ST_DISC : ST_IDLE;

    assign crc_start = (state_q == ST_IDLE) && accept;
    assign crc_en    = ((state_q == ST_RECV) && in_valid) || (state_q == ST_PAD);
    assign crc_din   = (state_q == ST_PAD) ? 8'h00 : in_byte;

    rxw_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .start   (crc_start),
        .en      (crc_en),
        .din     (crc_din),
        .crc_fin (crc_fin)
    );

    rxw_meta #(
        .PAGE_BYTES (PAGE_BYTES),
        .LONG_FRAME (LONG_FRAME),
        .CNT_W      (CNT_W)
    ) u_meta (
        .cnt   (cnt_q),
        .strip (strip_q),
        .meta  (meta)
    );

    assign tw = tail_write(step_q, meta, crc_fin, last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            cnt_q         <= '0;
            cur_page      <= '0;
            strip_q       <= 1'b0;
            last_q        <= 8'h00;
            step_q        <= 4'd0;
            swallow_q     <= 1'b0;
            wr_en         <= 1'b0;
            wr_addr       <= '0;
            wr_data       <= 8'h00;
            push_valid    <= 1'b0;
            release_valid <= 1'b0;
        end else begin
            wr_en         <= 1'b0;
            push_valid    <= 1'b0;
            release_valid <= 1'b0;
            if (busy) begin
                swallow_q <= swallow_nxt;
            end
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        if (accept) begin
                            cur_page <= alloc_page;
                            strip_q  <= rcv_ctrl[CTRL_STRIP_BIT];
                            cnt_q    <= CNT_W'(1);
                            last_q   <= in_byte;
                            wr_en    <= 1'b1;
                            wr_addr  <= AW'(4);
                            wr_data  <= in_byte;
                            if (in_last) begin
                                state_q <= (CNT_W'(1) < MIN_C) ? ST_PAD : ST_CHECK;
                            end else begin
                                state_q <= ST_RECV;
                            end
                        end else if (!in_last) begin
                            state_q <= ST_DISC;
                        end
                    end
                end
                ST_RECV: begin
                    if (in_valid) begin
                        cnt_q  <= cnt_inc;
                        last_q <= in_byte;
                        if (data_in_range) begin
                            wr_en   <= 1'b1;
                            wr_addr <= AW'(data_addr);
                            wr_data <= in_byte;
                        end
                        if (in_last) begin
                            state_q <= (cnt_inc < MIN_C) ? ST_PAD : ST_CHECK;
                        end
                    end
                end
                ST_DISC: begin
                    if (in_valid && in_last) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_PAD: begin
                    wr_en   <= 1'b1;
                    wr_addr <= AW'(data_addr);
                    wr_data <= 8'h00;
                    cnt_q   <= cnt_inc;
                    if (cnt_inc >= MIN_C) begin
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (meta.oversize) begin
                        release_valid <= 1'b1;
                        state_q       <= finish_st;
                        swallow_q     <= 1'b0;
                    end else begin
                        step_q  <= strip_q ? 4'd4 : 4'd0;
                        state_q <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    wr_en   <= 1'b1;
                    wr_addr <= AW'(tw.addr);
                    wr_data <= tw.data;
                    if (step_q == LAST_STEP) begin
                        push_valid <= 1'b1;
                        state_q    <= finish_st;
                        swallow_q  <= 1'b0;
                    end else begin
                        step_q <= step_q + 4'd1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: the push coincides with the final header byte write
    assert_push_with_hdr_R9: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> (wr_en && wr_addr == AW'(3)));

    // R9: the push is a single-cycle pulse
    assert_push_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        push_valid |=> !push_valid);

    // R4: a frame ends either pushed or released, never both
    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (rst)
        !(push_valid && release_valid));

    // R4: no tail writes for a frame that does not fit
    assert_no_tail_oversize_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAIL) |-> !meta.oversize);

    // R2: padding cycles write zero bytes
    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAD) |=> (wr_en && wr_data == 8'h00));

    // R1: a frame refused by the control word writes nothing
    assert_refuse_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && in_valid && !rx_ok) |=> (!wr_en && state_q != ST_RECV));
endmodule

// File: tb/rx_page_writer_bench.sv
`timescale 1ns/1ps
module rx_page_writer_bench;
    localparam int PB   = 256;
    localparam int PNW  = 6;
    localparam int MINF = 64;
    localparam int LONG = 200;
    localparam int AW   = $clog2(PB);
    localparam int NV   = 10;

    // {length, strip flag, seed}
    localparam logic [31:0] VEC [NV] = '{
        {16'd70,  8'd0, 8'd1},
        {16'd71,  8'd0, 8'd2},
        {16'd10,  8'd0, 8'd3},
        {16'd63,  8'd0, 8'd4},
        {16'd64,  8'd1, 8'd5},
        {16'd201, 8'd1, 8'd6},
        {16'd250, 8'd1, 8'd7},
        {16'd247, 8'd0, 8'd8},
        {16'd1,   8'd1, 8'd9},
        {16'd99,  8'd1, 8'd10}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [15:0]    rcv_ctrl = 16'h0000;
    logic           in_valid = 1'b0;
    logic [7:0]     in_byte = 8'h00;
    logic           in_last = 1'b0;
    logic           alloc_req;
    logic           alloc_grant;
    logic [PNW-1:0] alloc_page;
    logic [PNW-1:0] cur_page;
    logic           wr_en;
    logic [AW-1:0]  wr_addr;
    logic [7:0]     wr_data;
    logic           push_valid;
    logic           release_valid;

    int checks = 0;
    int bad = 0;
    int push_cnt = 0;
    int rel_cnt = 0;
    int wr_cnt = 0;
    int req_cnt = 0;
    logic [PNW-1:0] last_push_page = '0;
    logic [PNW-1:0] last_rel_page = '0;
    logic [PNW-1:0] last_grant = '0;
    logic [3:0]     used = 4'h0;
    logic           fill = 1'b0;
    logic [7:0]     mem [PB];
    logic [7:0]     expm [PB];
    bit             done = 1'b0;

    always #10 clk = ~clk;

    rx_page_writer #(
        .PAGE_BYTES (PB),
        .PAGE_NUM_W (PNW),
        .MIN_FRAME  (MINF),
        .LONG_FRAME (LONG)
    ) u_rx_page_writer (
        .clk           (clk),
        .rst           (rst),
        .rcv_ctrl      (rcv_ctrl),
        .in_valid      (in_valid),
        .in_byte       (in_byte),
        .in_last       (in_last),
        .alloc_req     (alloc_req),
        .alloc_grant   (alloc_grant),
        .alloc_page    (alloc_page),
        .cur_page      (cur_page),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .push_valid    (push_valid),
        .release_valid (release_valid)
    );

    // Page allocator model: four pages, lowest free first.
    assign alloc_grant = (used != 4'hF) && !fill;
    always_comb begin
        alloc_page = '0;
        for (int i = 3; i >= 0; i--) begin
            if (!used[i]) alloc_page = PNW'(i);
        end
    end

    always @(posedge clk) begin
        logic [3:0] nxt;
        nxt = used;
        if (rst) begin
            nxt = 4'h0;
        end else begin
            if (alloc_req && alloc_grant) begin
                nxt[alloc_page[1:0]] = 1'b1;
                last_grant <= alloc_page;
            end
            if (release_valid || push_valid) nxt[cur_page[1:0]] = 1'b0;
        end
        used <= nxt;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                mem[wr_addr] = wr_data;
                wr_cnt++;
            end
            if (push_valid) begin
                push_cnt++;
                last_push_page = cur_page;
            end
            if (release_valid) begin
                rel_cnt++;
                last_rel_page = cur_page;
            end
            if (alloc_req) req_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int seed, input int i);
        return 8'(seed * 13 + i * 29 + 5);
    endfunction

    function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic fb;
        r = c;
        for (int k = 0; k < 8; k++) begin
            fb = r[0] ^ d[k];
            r  = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    // Builds the expected page image; returns the stored size.
    function automatic int build_exp(input int len, input bit strip, input int seed);
        int n, e, sz;
        bit odd, lng;
        logic [31:0] c;
        logic [7:0] b;
        n = (len < MINF) ? MINF : len;
        e = n & ~1;
        odd = n[0];
        lng = n > LONG;
        sz = e + 6 + (strip ? 0 : 4);
        for (int i = 0; i < PB; i++) expm[i] = 8'hEE;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            b = (i < len) ? gen(seed, i) : 8'h00;
            c = crc_bits(c, b);
            if (i < e && 4 + i < PB) expm[4 + i] = b;
        end
        c = ~c;
        if (sz <= PB) begin
            expm[0] = 8'h00;
            expm[1] = {3'b000, odd, lng, 3'b000};
            expm[2] = 8'(sz);
            expm[3] = 8'(sz >> 8);
            if (!strip) begin
                for (int k = 0; k < 4; k++) expm[4 + e + k] = c[8*k +: 8];
            end
            expm[sz - 2] = odd ? gen(seed, n - 1) : 8'h00;
            expm[sz - 1] = odd ? 8'h20 : 8'h00;
        end
        return sz;
    endfunction

    function automatic string region(input int idx, input int len, input int sz, input bit strip);
        int e;
        e = sz - 6 - (strip ? 0 : 4);
        if (idx < 2) return "R5 status";
        if (idx < 4) return "R3 size";
        if (idx < 4 + e) return (idx - 4 >= len) ? "R2 pad" : "R6 data";
        if (!strip && idx < 8 + e) return "R7 crc";
        return "R8 trailer";
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < PB; i++) mem[i] = 8'hEE;
    endtask

    task automatic send(input int len, input int seed, input bit hold);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_byte  = gen(seed, i);
            in_last  = (i == len - 1);
        end
        if (!hold) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_image(input int len, input bit strip, input int seed, input int sz);
        int first;
        first = -1;
        for (int i = 0; i < sz; i++) begin
            if (first < 0 && mem[i] !== expm[i]) first = i;
        end
        if (first >= 0) begin
            checks++;
            bad++;
            $display("FAIL %s: len=%0d offset=%0d actual=%0h expected=%0h",
                     region(first, len, sz, strip), len, first, mem[first], expm[first]);
        end else begin
            checks++;
        end
    endtask

    task automatic run_frame(input int len, input bit strip, input int seed);
        int p0, sz;
        clear_mem();
        rcv_ctrl = strip ? 16'h0300 : 16'h0100;
        p0 = push_cnt;
        send(len, seed, 1'b0);
        wait_cyc(100);
        sz = build_exp(len, strip, seed);
        chk(push_cnt == p0 + 1, "R9 push count", push_cnt - p0, 1);
        chk(last_push_page == last_grant, "R9 pushed page", int'(last_push_page), int'(last_grant));
        check_image(len, strip, seed, sz);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int w0, p0, r0, q0, sz;
        clear_mem();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(wr_en == 1'b0 && push_valid == 1'b0 && release_valid == 1'b0 && alloc_req == 1'b0,
            "reset outputs (R1 R9)", int'({wr_en, push_valid, release_valid, alloc_req}), 0);

        // Table of frames: R2 R3 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            run_frame(int'(VEC[v][31:16]), VEC[v][8], int'(VEC[v][7:0]));
        end

        // R4: 248 bytes with CRC kept needs 258 bytes in a 256-byte page
        clear_mem();
        rcv_ctrl = 16'h0100;
        p0 = push_cnt; r0 = rel_cnt;
        send(248, 11, 1'b0);
        wait_cyc(100);
        chk(push_cnt == p0, "R4 no push on oversize", push_cnt - p0, 0);
        chk(rel_cnt == r0 + 1, "R4 release pulse", rel_cnt - r0, 1);
        chk(last_rel_page == last_grant, "R4 released page", int'(last_rel_page), int'(last_grant));

        // R1: receive disabled
        rcv_ctrl = 16'h0000;
        w0 = wr_cnt; p0 = push_cnt; q0 = req_cnt;
        send(70, 12, 1'b0);
        wait_cyc(100);
        chk(wr_cnt == w0 && push_cnt == p0, "R1 disabled writes", wr_cnt - w0, 0);
        chk(req_cnt == q0, "R1 disabled no request", req_cnt - q0, 0);

        // R1: soft reset held with enable set
        rcv_ctrl = 16'h8100;
        w0 = wr_cnt; p0 = push_cnt; q0 = req_cnt;
        send(70, 13, 1'b0);
        wait_cyc(100);
        chk(wr_cnt == w0 && push_cnt == p0, "R1 soft reset writes", wr_cnt - w0, 0);
        chk(req_cnt == q0, "R1 soft reset no request", req_cnt - q0, 0);

        // R1: no free page
        rcv_ctrl = 16'h0100;
        fill = 1'b1;
        w0 = wr_cnt; p0 = push_cnt; q0 = req_cnt;
        send(70, 14, 1'b0);
        wait_cyc(100);
        chk(req_cnt == q0 + 1, "R1 request when full", req_cnt - q0, 1);
        chk(wr_cnt == w0 && push_cnt == p0, "R1 full writes", wr_cnt - w0, 0);
        fill = 1'b0;
        wait_cyc(2);

        // R10: a frame arriving while the previous one is padded is discarded
        clear_mem();
        rcv_ctrl = 16'h0100;
        p0 = push_cnt;
        send(10, 15, 1'b1);
        send(100, 16, 1'b0);
        wait_cyc(100);
        sz = build_exp(10, 1'b0, 15);
        chk(push_cnt == p0 + 1, "R10 single push", push_cnt - p0, 1);
        check_image(10, 1'b0, 15, sz);

        // R10: normal reception resumes afterwards
        run_frame(70, 1'b0, 17);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule